// File: doc/BRIEF.md
# Glitch-Free Selectable Clock Post-Divider

This block divides a fast input clock by 1, 2, 4 or 8, picked by a 2-bit ratio code, and drives the result as a true/complement clock pair. Every divided ratio has a 50% duty cycle. At ratio one the input clock passes straight through a gate. That gate only opens or closes while the input clock is low.

An active-high output enable starts and stops the output without runt pulses. The enable is taken into the output clock domain and acts only at the end of a high phase. A stopped output rests with the true side low and the complement side high. The ratio code may change while the clock runs. A new code takes effect only at the end of a high phase, so a high phase in progress is never cut short. The low phase that follows already uses the new ratio.

All internal state moves on the falling edge of the input clock. A single phase counter measures the half-period of the divided ratios.

Top module: `pdiv_post_divider`

## Requirements
- R1: Ratio code encoding is 2'b00 = divide by 2, 2'b01 = divide by 4, 2'b10 = divide by 8, 2'b11 = divide by 1. The output period equals that many input clock periods.
- R2: For ratios 2, 4 and 8, high and low phases each last exactly half the output period. At ratio 1 the output follows the input clock waveform. A high phase is never ended early.
- R3: The enable input is acted on only at the end of an output high phase. Toggling it at any time never produces a high or low phase shorter than the half-period of the active ratio.
- R4: While disabled, clk_p stays at logic low and clk_n at logic high.
- R5: clk_n is the inverse of clk_p at all times.
- R6: A change of ratio code is applied at the end of the current high phase. The high phase in progress keeps its full old width, and the following low phase has the new half-period.
- R7: While rst_n is low, clk_p is low and clk_n is high, even with the enable asserted at ratio 1.
- R8: At ratio 1 the gate opens only while the input clock is low. After a restart, the first high pulse is a full input high phase.
- R9: On re-enable at a divided ratio, the output begins with a complete low phase of the new half-period, measured from the falling input edge that samples the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_code | input | 2 | Ratio select code (see R1) |
| out_en | input | 1 | Output enable, active high |
| clk_p | output | 1 | Divided clock, true side |
| clk_n | output | 1 | Divided clock, complement side |

## Verification
A corrupted phase counter or output level shows at the ports as a wrong high or low width within one output period. A ratio register loaded at the wrong moment does the same: the next phase after the fault comes out shortened or stretched. If the run state goes wrong, the output either keeps toggling after the enable falls or stays parked after it rises. That is visible within one half-period of the slowest ratio, eight input half-cycles. The bench samples the pair in the middle of every input half-cycle, so any of these faults turns into a run length that differs from the one the requirements predict.

// File: rtl/pdiv_pkg.sv
`timescale 1ns/1ps
package pdiv_pkg;

  typedef enum logic [1:0] {
    RATIO_2 = 2'b00,
    RATIO_4 = 2'b01,
    RATIO_8 = 2'b10,
    RATIO_1 = 2'b11
  } ratio_e;

  localparam int MAX_HALF = 4;
  localparam int CNT_W    = $clog2(MAX_HALF);

  // Half period in input cycles, minus one (terminal count of the phase counter).
  function automatic logic [CNT_W-1:0] half_limit(input ratio_e r);
    case (r)
      RATIO_4: half_limit = CNT_W'(1);
      RATIO_8: half_limit = CNT_W'(3);
      default: half_limit = '0;
    endcase
  endfunction

endpackage

// File: rtl/pdiv_phase_cnt.sv
`timescale 1ns/1ps
module pdiv_phase_cnt #(
  parameter int W = 2
) (
  input  logic         clk_in,
  input  logic         rst_n,
  input  logic         clear,
  input  logic [W-1:0] limit,
  output logic         term
);

  logic [W-1:0] cnt_q;

  assign term = (cnt_q == limit);

  always_ff @(negedge clk_in or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clear || term)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + W'(1);
  end

  AST_CNT_IN_RANGE: assert property (@(negedge clk_in) disable iff (!rst_n)
    !clear |-> (cnt_q <= limit)); // R1

endmodule

// File: rtl/pdiv_ctrl.sv
`timescale 1ns/1ps
module pdiv_ctrl
  import pdiv_pkg::*;
(
  input  logic             clk_in,
  input  logic             rst_n,
  input  logic [1:0]       div_code,
  input  logic             out_en,
  input  logic             term,
  output logic             run,
  output logic             level,
  output logic             unity,
  output logic             cnt_clear,
  output logic [CNT_W-1:0] cnt_limit
);

  ratio_e cur_q, nxt;
  logic   run_q, lvl_q;
  logic   fall_bnd;

  assign nxt      = ratio_e'(div_code);
  assign unity    = (cur_q == RATIO_1);
  // End of a high phase: the only moment ratio and enable may change.
  assign fall_bnd = run_q & (unity | (lvl_q & term));

  assign run       = run_q;
  assign level     = lvl_q;
  assign cnt_clear = ~run_q | unity;
  assign cnt_limit = half_limit(cur_q);

  always_ff @(negedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      lvl_q <= 1'b0;
      cur_q <= RATIO_2;
    end else if (!run_q) begin
      if (out_en) begin
        run_q <= 1'b1;
        cur_q <= nxt;
        lvl_q <= (nxt == RATIO_1);
      end else begin
        lvl_q <= 1'b0;
      end
    end else if (fall_bnd) begin
      if (!out_en) begin
        run_q <= 1'b0;
        lvl_q <= 1'b0;
      end else begin
        cur_q <= nxt;
        lvl_q <= (nxt == RATIO_1);
      end
    end else if (term) begin
      lvl_q <= 1'b1;
    end
  end

  AST_CODE_AT_BOUNDARY: assert property (@(negedge clk_in) disable iff (!rst_n)
    (run_q && !fall_bnd) |=> $stable(cur_q)); // R6

  AST_ENABLE_AT_BOUNDARY: assert property (@(negedge clk_in) disable iff (!rst_n)
    (run_q && !fall_bnd) |=> run_q); // R3

  AST_HIGH_NOT_CUT: assert property (@(negedge clk_in) disable iff (!rst_n)
    (run_q && lvl_q && !unity && !term) |=> lvl_q); // R2

  AST_PARK_ENTRY_LOW: assert property (@(negedge clk_in) disable iff (!rst_n)
    $fell(run_q) |-> !lvl_q); // R4

endmodule

// File: rtl/pdiv_out_stage.sv
`timescale 1ns/1ps
module pdiv_out_stage (
  input  logic clk_in,
  input  logic rst_n,
  input  logic run,
  input  logic level,
  input  logic unity,
  output logic clk_p,
  output logic clk_n
);

  logic pass;

  // At ratio one the level flop acts as a falling-edge gate on the input clock.
  assign pass  = unity ? clk_in : 1'b1;
  assign clk_p = level & pass;
  assign clk_n = ~clk_p;

  AST_PARKED_LOW: assert property (@(negedge clk_in) disable iff (!rst_n)
    !run |-> (!clk_p && clk_n)); // R4

  AST_UNITY_PASS: assert property (@(negedge clk_in) disable iff (!rst_n)
    (run && unity && level) |-> clk_p); // R8

endmodule

// File: rtl/pdiv_post_divider.sv
`timescale 1ns/1ps
module pdiv_post_divider
  import pdiv_pkg::*;
(
  input  logic       clk_in,
  input  logic       rst_n,
  input  logic [1:0] div_code,
  input  logic       out_en,
  output logic       clk_p,
  output logic       clk_n
);

  logic             term, run, level, unity, cnt_clear;
  logic [CNT_W-1:0] cnt_limit;

  pdiv_ctrl u_ctrl (
    .clk_in    (clk_in),
    .rst_n     (rst_n),
    .div_code  (div_code),
    .out_en    (out_en),
    .term      (term),
    .run       (run),
    .level     (level),
    .unity     (unity),
    .cnt_clear (cnt_clear),
    .cnt_limit (cnt_limit)
  );

  pdiv_phase_cnt #(.W(CNT_W)) u_cnt (
    .clk_in (clk_in),
    .rst_n  (rst_n),
    .clear  (cnt_clear),
    .limit  (cnt_limit),
    .term   (term)
  );

  pdiv_out_stage u_out (
    .clk_in (clk_in),
    .rst_n  (rst_n),
    .run    (run),
    .level  (level),
    .unity  (unity),
    .clk_p  (clk_p),
    .clk_n  (clk_n)
  );

endmodule

// File: tb/pdiv_post_divider_test.sv
`timescale 1ns/1ps
module pdiv_post_divider_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] div_code = 2'b11;
  logic out_en = 1'b1;
  logic clk_p, clk_n;

  int checks = 0, errors = 0;
  int compl_bad = 0;
  logic prev_p = 1'b0;
  int rl = 0, min_run = 1000;
  bit trk = 0, trk_skip = 0;

  always #10 clk = ~clk;   // 50 MHz

  pdiv_post_divider uut (
    .clk_in(clk), .rst_n(rst_n), .div_code(div_code),
    .out_en(out_en), .clk_p(clk_p), .clk_n(clk_n)
  );

  typedef struct packed { logic [1:0] code; logic [3:0] half; } vec_t;
  // Expected phase width in input half-cycles: 00->2, 01->4, 10->8, 11->1 (R1, R2)
  localparam vec_t VEC [8] = '{
    '{2'b00, 4'd2}, '{2'b01, 4'd4}, '{2'b10, 4'd8}, '{2'b11, 4'd1},
    '{2'b10, 4'd8}, '{2'b00, 4'd2}, '{2'b11, 4'd1}, '{2'b01, 4'd4}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Advance to mid-point of the next input half-cycle and sample the pair.
  task automatic half_step();
    @(clk); #5;
    if (clk_n !== ~clk_p) compl_bad++;
    if (clk_p === prev_p) rl++;
    else begin
      if (trk) begin
        if (trk_skip) trk_skip = 0;
        else if (rl < min_run) min_run = rl;
      end
      rl = 1;
    end
    prev_p = clk_p;
  endtask

  // Length of the run holding the current sample; leaves first sample of next run.
  task automatic get_run(output int len, output logic lvl);
    lvl = clk_p; len = 1;
    forever begin
      half_step();
      if (clk_p !== lvl || len >= 200) break;
      len++;
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    int h, g, n;
    logic l1, l2;

    // R7: reset holds pair parked even with enable at ratio one
    repeat (5) half_step();
    @(posedge clk); #5;
    chk(clk_p === 1'b0 && clk_n === 1'b1, "R7 reset pair", {clk_p, clk_n}, 2'b01);
    rst_n = 1'b1;

    // R1/R2: vector table of codes and widths
    for (int i = 0; i < 8; i++) begin
      div_code = VEC[i].code;
      repeat (40) half_step();
      get_run(h, l1);              // discard partial
      get_run(h, l1);
      get_run(g, l2);
      chk(h == int'(VEC[i].half), "R1 first phase width", h, VEC[i].half);
      chk(g == int'(VEC[i].half), "R2 second phase width", g, VEC[i].half);
    end

    // R6: code change in the middle of a divide-by-8 high phase
    div_code = 2'b10;
    repeat (40) half_step();
    do get_run(h, l1); while (l1 !== 1'b0);
    half_step(); half_step();
    div_code = 2'b00;
    get_run(h, l1);
    chk(h + 2 == 8 && l1 === 1'b1, "R6 old high kept", h + 2, 8);
    get_run(g, l2);
    chk(g == 2, "R6 new low width", g, 2);

    // R4: disable parks the pair
    div_code = 2'b01;
    out_en = 1'b0;
    repeat (40) half_step();
    n = 0;
    for (int k = 0; k < 20; k++) begin
      half_step();
      if (clk_p !== 1'b0 || clk_n !== 1'b1) n++;
    end
    chk(n == 0, "R4 parked samples not low/high", n, 0);

    // R9: restart at divide-by-4 begins with a full low phase
    @(posedge clk); #1; out_en = 1'b1;
    n = 0;
    forever begin
      half_step();
      if (clk_p === 1'b1 || n >= 100) break;
      n++;
    end
    chk(n == 4, "R9 first low after enable", n, 4);

    // R8: restart at ratio one gives a full input high phase next
    out_en = 1'b0; div_code = 2'b11;
    repeat (30) half_step();
    @(posedge clk); #1; out_en = 1'b1;
    n = 0;
    forever begin
      half_step();
      if (clk_p === 1'b1 || n >= 100) break;
      n++;
    end
    chk(n == 1, "R8 low samples before first pass", n, 1);
    get_run(h, l1);
    chk(h == 1, "R8 first pass width", h, 1);

    // R3: enable toggling at divide-by-4 creates no short phase
    div_code = 2'b01;
    repeat (30) half_step();
    trk = 1; trk_skip = 1; min_run = 1000;
    for (int i = 0; i < 16; i++) begin
      repeat (2 + (i * 3) % 7) half_step();
      out_en = ~out_en;
    end
    out_en = 1'b1;
    repeat (30) half_step();
    trk = 0;
    chk(min_run >= 4, "R3 min phase with enable toggles (div4)", min_run, 4);

    // R3: same at divide-by-2
    div_code = 2'b00;
    repeat (20) half_step();
    trk = 1; trk_skip = 1; min_run = 1000;
    for (int i = 0; i < 16; i++) begin
      repeat (1 + (i * 5) % 4) half_step();
      out_en = ~out_en;
    end
    out_en = 1'b1;
    repeat (20) half_step();
    trk = 0;
    chk(min_run >= 2, "R3 min phase with enable toggles (div2)", min_run, 2);

    // R6: ratio code storm among divided ratios never gives a runt
    trk = 1; trk_skip = 1; min_run = 1000;
    for (int j = 0; j < 24; j++) begin
      repeat (1 + (j * 7) % 9) half_step();
      case ((j * 2) % 3)
        0: div_code = 2'b00;
        1: div_code = 2'b01;
        default: div_code = 2'b10;
      endcase
    end
    repeat (30) half_step();
    trk = 0;
    chk(min_run >= 2, "R6 min phase across code changes", min_run, 2);

    // R5: complement seen at every sample
    chk(compl_bad == 0, "R5 complement mismatches", compl_bad, 0);

    summary();
    $finish;
  end

endmodule